// File: doc/BRIEF.md
# Receive Drop Statistics Counter

This block keeps a 16-bit tally of received frames that an Ethernet receive MAC had to throw away even though they were otherwise good. A frame is tallied when the MAC signals the end of its drop decision and at least one of three drop causes is present: receive FIFO overflow, a parity error, or reception switched off. Frames that the address-recognition filter turned away are never tallied, and several causes on one frame count as one.

Software sees the tally through a simple 32-bit register port. Reading the count register returns the tally and empties it in the same access, so software accumulates the long-run total itself. Software may also preload the tally, for instance to 0x7F00 so that an alert comes after 256 more drops. When an increment carries the tally from 0x7FFF to 0x8000, a sticky rollover flag is set, and an interrupt line follows that flag while its enable bit is on. A hardware reset empties everything; a soft reset clears the flag and enable but keeps the tally.

Top module: `rx_drop_counter`

## Requirements
- R1: After hardware reset (rst_n low at a clock edge) the tally reads 0, the control register reads 0 and irq is low.
- R2: A cycle with frame_done high, drop_cause non-zero (bit 0 FIFO overflow, bit 1 parity error, bit 2 reception disabled) and addr_reject low adds exactly 1 to the tally, whichever and however many cause bits are set.
- R3: A cycle with addr_reject high, or with drop_cause zero, or with frame_done low, leaves the tally unchanged.
- R4: A read (reg_sel high, reg_wr low) at byte offset 0x7C returns the tally in reg_rdata[15:0] and sets the tally to 0 at that clock edge; if a counted drop occurs in the same cycle the tally becomes 1.
- R5: A write at offset 0x7C loads reg_wdata[15:0] into the tally and ignores reg_wdata[31:16]; a counted drop in the same cycle makes the tally the written value plus 1.
- R6: An increment from 0x7FFF to 0x8000 sets the rollover flag, read at control offset 0x00 bit 0; it stays set until a write to offset 0x00 with bit 0 at 1; writing bit 0 as 0 leaves it; a new rollover in the same cycle as such a clearing write leaves it set.
- R7: irq is high exactly when the rollover flag and the interrupt enable (control offset 0x00 bit 1, read/write) are both 1.
- R8: An increment from 0xFFFF wraps the tally to 0x0000 and does not set the rollover flag.
- R9: A cycle with soft_rst high clears the rollover flag and the interrupt enable and leaves the tally unchanged.
- R10: Reads return 0 in bits 31:16 of the count register and in bits 31:2 of the control register; reads at any other offset return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high; keeps the tally |
| frame_done | input | 1 | Drop decision strobe for one received valid frame |
| drop_cause | input | 3 | Drop causes: bit 0 FIFO overflow, bit 1 parity error, bit 2 reception disabled |
| addr_reject | input | 1 | Frame was turned away by the address filter |
| reg_sel | input | 1 | Register access strobe, one access per cycle |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq | output | 1 | Rollover interrupt |

## Verification
The embedded assertions watch every cycle that a filter rejection never produces an increment, that a clearing read leaves the tally at exactly the increment of that cycle, that an idle cycle holds the tally, that a rollover pulse is followed by 0x8000 and a set flag, that the 0xFFFF wrap never pulses rollover, and that reserved read bits stay zero. The directed scenarios show what spans several accesses: preloading 0x7F00 and seeing the flag and interrupt arrive on the 256th drop and not earlier, the write-one-to-clear rules including a rollover racing a clearing write, the soft reset keeping the tally, and reads racing drops.

// File: rtl/rx_drop_pkg.sv
// Shared constants for the receive drop statistics counter.
// Assumes byte offsets on the register port and one access per cycle.
package rx_drop_pkg;

    // Index of each drop cause on the cause vector
    typedef enum int unsigned {
        CAUSE_FIFO_OVF = 0,
        CAUSE_PARITY   = 1,
        CAUSE_RX_OFF   = 2
    } drop_cause_e;

    localparam int unsigned NUM_CAUSES   = 3;

    // Control register field positions
    localparam int unsigned CTRL_STS_BIT = 0;
    localparam int unsigned CTRL_EN_BIT  = 1;

    // Kind of register access decoded this cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/drop_event_qual.sv
// Turns the per-frame drop strobe and its cause bits into one count pulse.
// Assumes frame_done_i is high for one cycle per frame; any number of
// causes on one frame yields a single pulse; filter rejects yield none.
module drop_event_qual #(
    parameter int unsigned N_CAUSE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done_i,
    input  logic [N_CAUSE-1:0] cause_i,
    input  logic               reject_i,
    output logic               inc_o
);

    logic [N_CAUSE:0] any_chain;

    // Ripple OR over the cause bits, one stage per cause
    assign any_chain[0] = 1'b0;
    for (genvar g = 0; g < N_CAUSE; g++) begin : g_cause
        assign any_chain[g+1] = any_chain[g] | cause_i[g];
    end

    // One pulse for a frame dropped by at least one cause and not filtered
    always_comb begin
        inc_o = frame_done_i && any_chain[N_CAUSE] && !reject_i;
    end

    // R3
    reject_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_i || !frame_done_i || (cause_i == '0)) |-> !inc_o);

endmodule

// File: rtl/drop_counter_core.sv
// Holds the tally with load, clear-on-read and increment in one step.
// Assumes load and clear never need to be seen together; load wins.
// The increment is applied on top of whatever base load or clear picks,
// so no drop is lost to a simultaneous register access.
module drop_counter_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             roll_o
);

    localparam logic [CNT_W-1:0] ROLL_FROM = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] ROLL_TO   = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_nxt;

    // Pick the starting value: written value, zero after a read, or held
    always_comb begin
        if (load_i)      base = load_val_i;
        else if (clr_i)  base = '0;
        else             base = cnt_q;
    end

    // Add the drop of this cycle and flag the midpoint crossing
    always_comb begin
        cnt_nxt = inc_i ? base + ONE : base;
        roll_o  = inc_i && (base == ROLL_FROM);
    end

    // Tally register; only the hardware reset empties it
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    assign cnt_o = cnt_q;

    // R4
    clear_leaves_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> (cnt_q == (($past(inc_i)) ? ONE : '0)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_i && !inc_i) |=> $stable(cnt_q));

    // R6
    roll_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll_o |=> (cnt_q == ROLL_TO));

    // R8
    wrap_no_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && !clr_i && (cnt_q == CNT_MAX)) |-> !roll_o);

endmodule

// File: rtl/rollover_status.sv
// Sticky rollover flag, its interrupt enable and the interrupt output.
// Assumes a soft reset outranks everything, and that a new rollover
// outranks a write-one-to-clear arriving in the same cycle.
module rollover_status (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic set_i,
    input  logic ctrl_we_i,
    input  logic wr_clr_i,
    input  logic wr_en_i,
    output logic sts_o,
    output logic en_o,
    output logic irq_o
);

    logic sts_q;
    logic en_q;

    // Sticky flag: set by rollover, cleared by writing one or by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)                     sts_q <= 1'b0;
        else if (soft_rst_i)            sts_q <= 1'b0;
        else if (set_i)                 sts_q <= 1'b1;
        else if (ctrl_we_i && wr_clr_i) sts_q <= 1'b0;
    end

    // Interrupt enable bit written by software
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= 1'b0;
        else if (soft_rst_i) en_q <= 1'b0;
        else if (ctrl_we_i)  en_q <= wr_en_i;
    end

    assign sts_o = sts_q;
    assign en_o  = en_q;
    assign irq_o = sts_q && en_q;

    // R6
    roll_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !soft_rst_i) |=> sts_q);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !soft_rst_i && !(ctrl_we_i && wr_clr_i)) |=> sts_q);

    // R9
    soft_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (!sts_q && !en_q));

endmodule

// File: rtl/rx_drop_counter.sv
// Top of the receive drop statistics counter: decodes the register port,
// feeds the tally core and the rollover status, and assembles read data.
// Assumes one access per cycle; read data is combinational in the cycle
// of the read, and the read's clearing takes effect at that clock edge.
module rx_drop_counter #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [7:0]  CNT_OFFSET  = 8'h7C,
    parameter logic [7:0]  CTRL_OFFSET = 8'h00
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               soft_rst,
    input  logic                               frame_done,
    input  logic [rx_drop_pkg::NUM_CAUSES-1:0] drop_cause,
    input  logic                               addr_reject,
    input  logic                               reg_sel,
    input  logic                               reg_wr,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic                               irq
);
    import rx_drop_pkg::*;

    localparam logic [ADDR_W-1:0] CNT_ADDR  = ADDR_W'(CNT_OFFSET);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);

    acc_kind_e        acc;
    logic             cnt_hit;
    logic             ctrl_hit;
    logic             inc;
    logic             roll;
    logic [CNT_W-1:0] cnt;
    logic             sts;
    logic             en;
    logic [DATA_W-1:0] cnt_word;

    // Classify the access of this cycle
    always_comb begin
        if (!reg_sel)    acc = ACC_NONE;
        else if (reg_wr) acc = ACC_WRITE;
        else             acc = ACC_READ;
    end

    // Match the two owned offsets
    always_comb begin
        cnt_hit  = (reg_addr == CNT_ADDR);
        ctrl_hit = (reg_addr == CTRL_ADDR);
    end

    drop_event_qual #(
        .N_CAUSE (NUM_CAUSES)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .cause_i      (drop_cause),
        .reject_i     (addr_reject),
        .inc_o        (inc)
    );

    drop_counter_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     ((acc == ACC_WRITE) && cnt_hit),
        .load_val_i (reg_wdata[CNT_W-1:0]),
        .clr_i      ((acc == ACC_READ) && cnt_hit),
        .inc_i      (inc),
        .cnt_o      (cnt),
        .roll_o     (roll)
    );

    rollover_status u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .set_i      (roll),
        .ctrl_we_i  ((acc == ACC_WRITE) && ctrl_hit),
        .wr_clr_i   (reg_wdata[CTRL_STS_BIT]),
        .wr_en_i    (reg_wdata[CTRL_EN_BIT]),
        .sts_o      (sts),
        .en_o       (en),
        .irq_o      (irq)
    );

    // Widen the tally to the bus, padding reserved bits with zero
    if (CNT_W < DATA_W) begin : g_pad
        assign cnt_word = {{(DATA_W-CNT_W){1'b0}}, cnt};
    end else begin : g_full
        assign cnt_word = cnt;
    end

    // Read data mux; unowned offsets and non-read cycles return zero
    always_comb begin
        reg_rdata = '0;
        if (acc == ACC_READ) begin
            if (cnt_hit) begin
                reg_rdata = cnt_word;
            end else if (ctrl_hit) begin
                reg_rdata[CTRL_STS_BIT] = sts;
                reg_rdata[CTRL_EN_BIT]  = en;
            end
        end
    end

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:CNT_W] == '0));

    // R10
    other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_hit && !ctrl_hit) |-> (reg_rdata == '0));

    // R7
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && ctrl_hit) |-> (irq == (reg_rdata[CTRL_STS_BIT] && reg_rdata[CTRL_EN_BIT])));

endmodule

// File: tb/tb_rx_drop_counter.sv
`timescale 1ns/1ps
module tb_rx_drop_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        frame_done = 1'b0;
    logic [2:0]  drop_cause = 3'b000;
    logic        addr_reject = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_CNT  = 8'h7C;
    localparam logic [7:0] A_CTRL = 8'h00;

    always #2 clk = ~clk;

    rx_drop_counter dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .frame_done(frame_done), .drop_cause(drop_cause), .addr_reject(addr_reject),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic drop(logic [2:0] c, logic rej);
        frame_done = 1'b1; drop_cause = c; addr_reject = rej;
        @(negedge clk);
        frame_done = 1'b0; drop_cause = 3'b000; addr_reject = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_CNT, d);  check("R1 count", d, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        drop(3'b001, 1'b0);
        drop(3'b010, 1'b0);
        drop(3'b100, 1'b0);
        drop(3'b111, 1'b0);
        rd(A_CNT, d); check("R2 four drops", d, 32'd4);
        rd(A_CNT, d); check("R4 cleared", d, 32'd0);
    endtask

    task automatic t_reject();
        logic [31:0] d;
        drop(3'b111, 1'b1);
        drop(3'b001, 1'b1);
        drop(3'b000, 1'b0);
        drop_cause = 3'b011; @(negedge clk); drop_cause = 3'b000;
        rd(A_CNT, d); check("R3 nothing counted", d, 32'd0);
    endtask

    task automatic t_read_race();
        logic [31:0] d;
        drop(3'b010, 1'b0);
        drop(3'b010, 1'b0);
        frame_done = 1'b1; drop_cause = 3'b001;
        rd(A_CNT, d);
        frame_done = 1'b0; drop_cause = 3'b000;
        check("R4 read value", d, 32'd2);
        rd(A_CNT, d); check("R4 race leaves one", d, 32'd1);
    endtask

    task automatic t_load();
        logic [31:0] d;
        wr(A_CNT, 32'hABCD_1234);
        rd(A_CNT, d); check("R5 load low half", d, 32'h0000_1234);
        frame_done = 1'b1; drop_cause = 3'b100;
        wr(A_CNT, 32'h0000_0010);
        frame_done = 1'b0; drop_cause = 3'b000;
        rd(A_CNT, d); check("R5 load plus drop", d, 32'h11);
    endtask

    task automatic t_roll();
        logic [31:0] d;
        wr(A_CTRL, 32'h2);
        wr(A_CNT, 32'h7F00);
        for (int i = 0; i < 255; i++) drop(3'b001, 1'b0);
        check("R7 no irq before 256", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R6 flag not yet", d, 32'h2);
        drop(3'b001, 1'b0);
        check("R7 irq on roll", {31'b0, irq}, 32'h1);
        rd(A_CTRL, d); check("R6 flag set", d, 32'h3);
        rd(A_CNT, d);  check("R6 count 0x8000", d, 32'h8000);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, d); check("R6 write zero keeps", d, 32'h3);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, d); check("R6 w1c clears", d, 32'h2);
        check("R7 irq low after clear", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h7FFF);
        drop(3'b010, 1'b0);
        check("R7 irq masked", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R6 flag with enable off", d, 32'h1);
        wr(A_CTRL, 32'h2);
        check("R7 irq on enable", {31'b0, irq}, 32'h1);
        // Rollover in the same cycle as a clearing write
        wr(A_CNT, 32'h7FFF);
        frame_done = 1'b1; drop_cause = 3'b001;
        wr(A_CTRL, 32'h3);
        frame_done = 1'b0; drop_cause = 3'b000;
        rd(A_CTRL, d); check("R6 set beats clear", d, 32'h3);
        wr(A_CTRL, 32'h1);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(A_CNT, 32'hFFFF);
        drop(3'b100, 1'b0);
        rd(A_CTRL, d); check("R8 no flag on wrap", d, 32'h0);
        rd(A_CNT, d);  check("R8 wrapped to zero", d, 32'h0);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(A_CTRL, 32'h2);
        wr(A_CNT, 32'h7FFF);
        drop(3'b001, 1'b0);
        wr(A_CNT, 32'h0055);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        check("R9 irq low", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R9 ctrl cleared", d, 32'h0);
        rd(A_CNT, d);  check("R9 count kept", d, 32'h55);
    endtask

    task automatic t_other();
        logic [31:0] d;
        wr(A_CNT, 32'h0042);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d);  check("R10 other offset", d, 32'h0);
        rd(A_CTRL, d); check("R10 ctrl untouched", d, 32'h0);
        rd(A_CNT, d);  check("R10 count untouched", d, 32'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_reject();
        t_read_race();
        t_load();
        t_roll();
        t_wrap();
        t_soft();
        t_other();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule